// File: doc/BRIEF.md
# Commit-Gated Memory Operation Buffer

This block sits between instruction dispatch and the memory controller of an out-of-order core. It keeps memory operations in program order in a circular queue. It captures address and store-data operands from a result bus as they become known. It issues the operations one at a time from the oldest entry. Ordinary loads leave as soon as their address is known and they reach the head. Stores and loads aimed at the IO window are different: they are reported to the reorder buffer when ready, and they go to memory only after the reorder buffer commits them. A speculative path therefore can never write memory or consume an input byte.

When the core detects a mispredicted branch it raises the flush stall. While the stall is high, the buffer accepts no new operations and discards every entry that is not yet committed. It still finishes the committed stores that remain at its head. If an uncommitted load is already in flight, it is allowed to complete on the memory side, but its result is suppressed. The buffer also raises an early-full flag, so the fetch side can stop one cycle before the queue runs out of space.

Top module: `mem_order_buffer`

## Requirements
- R1: After reset the buffer is empty. `full_next`, `mem_req`, `ld_valid` and `rdy_valid` are all low.
- R2: A store is reported once on `rdy_valid`/`rdy_tag` after both its address and its data are known. A load whose address is at or above 0x30000 is reported once after its address is known.
- R3: A store never raises `mem_req` before its tag arrives on `commit_valid`/`commit_tag`. After commit it is written with `mem_we`=1 and its own address and data.
- R4: A load below 0x30000 issues with `mem_we`=0 once its address is known and it is the oldest entry. One cycle after `mem_done`, its tag and `mem_rdata` appear for exactly one cycle on `ld_valid`/`ld_tag`/`ld_data`.
- R5: A load at or above 0x30000 is not sent to memory until it is committed.
- R6: Operations issue strictly oldest first, with at most one request outstanding. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_done`.
- R7: A pending operand is taken from `wb_value` when `wb_valid` is high and `wb_tag` matches, including in the cycle in which the operation is dispatched.
- R8: `full_next` is high exactly when occupancy is at least DEPTH-1. A dispatch while DEPTH entries are held is dropped.
- R9: While `flush` is high, dispatch is ignored and uncommitted entries are discarded. Committed stores are still written to memory.
- R10: An uncommitted load that is already in flight when `flush` rises completes its memory access, but it produces no `ld_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch a memory operation |
| disp_is_st | input | 1 | 1 = store, 0 = load |
| disp_rob_tag | input | 4 | Reorder-buffer tag of the operation |
| disp_addr_ok | input | 1 | Address value is already known |
| disp_addr | input | 32 | Address value |
| disp_addr_q | input | 4 | Producer tag of a pending address |
| disp_data_ok | input | 1 | Store data is already known |
| disp_data | input | 32 | Store data value |
| disp_data_q | input | 4 | Producer tag of pending store data |
| full_next | output | 1 | Buffer will be full next cycle |
| wb_valid | input | 1 | Result bus valid |
| wb_tag | input | 4 | Result bus producer tag |
| wb_value | input | 32 | Result bus value |
| rdy_valid | output | 1 | A commit-gated entry is ready |
| rdy_tag | output | 4 | Tag of the ready entry |
| commit_valid | input | 1 | Reorder buffer commits a tag |
| commit_tag | input | 4 | Committed tag |
| flush | input | 1 | Mispredict stall / flush |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_done | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_done` |
| ld_valid | output | 1 | Load result broadcast |
| ld_tag | output | 4 | Tag of the load result |
| ld_data | output | 32 | Load result value |

## Verification
A lost commit flag would leave a store stuck at the head. `mem_req` would then stay low after commit, and the bench's write count falls short within a few cycles. A head or tail pointer left wrong after a flush shows up at the next load. The load returns the value of a discarded store, or it is replaced by a stale entry's tag on `ld_tag`, and this is visible within one memory round trip. A miscounted occupancy appears directly on `full_next` the cycle after the dispatch that crosses DEPTH-1. It also shows as a write count that is one too high or too low after a burst fills the queue.

// File: rtl/mob_pkg.sv
package mob_pkg;
  localparam int XLEN  = 32;
  localparam int TAG_W = 4;

  typedef struct packed {
    logic             is_st;
    logic             addr_ok;
    logic [XLEN-1:0]  addr;
    logic [TAG_W-1:0] addr_q;
    logic             data_ok;
    logic [XLEN-1:0]  data;
    logic [TAG_W-1:0] data_q;
    logic [TAG_W-1:0] rob_tag;
    logic             committed;
    logic             reported;
  } mob_entry_t;
endpackage

// File: rtl/mob_oldest_pick.sv
module mob_oldest_pick #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [PW-1:0]    start,
  output logic             found,
  output logic [PW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = start;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (cand[start + PW'(k)]) begin
        found = 1'b1;
        idx   = start + PW'(k);
      end
    end
  end
endmodule

// File: rtl/mob_popcount.sv
module mob_popcount #(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int k = 0; k < N; k++) ones = ones + CW'(bits[k]);
  end
endmodule

// File: rtl/mem_order_buffer.sv
module mem_order_buffer
  import mob_pkg::*;
#(
  parameter int               DEPTH   = 8,
  parameter logic [XLEN-1:0]  IO_BASE = 32'h0003_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic             disp_is_st,
  input  logic [TAG_W-1:0] disp_rob_tag,
  input  logic             disp_addr_ok,
  input  logic [XLEN-1:0]  disp_addr,
  input  logic [TAG_W-1:0] disp_addr_q,
  input  logic             disp_data_ok,
  input  logic [XLEN-1:0]  disp_data,
  input  logic [TAG_W-1:0] disp_data_q,
  output logic             full_next,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic [XLEN-1:0]  wb_value,
  output logic             rdy_valid,
  output logic [TAG_W-1:0] rdy_tag,
  input  logic             commit_valid,
  input  logic [TAG_W-1:0] commit_tag,
  input  logic             flush,
  output logic             mem_req,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic             mem_done,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             ld_valid,
  output logic [TAG_W-1:0] ld_tag,
  output logic [XLEN-1:0]  ld_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  assign rst_sn = rst_pipe[1];

  mob_entry_t       ent_q [DEPTH];
  mob_entry_t       ent_d [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]    count_q, count_d, kept_cnt;
  logic             busy_q, busy_d, kill_q, kill_d;
  logic             rdyv_d, ldv_d;
  logic [TAG_W-1:0] rdyt_d;

  mob_entry_t       hd, nent;
  logic             hd_io, disp_fire, pop, issue_ok;
  logic [DEPTH-1:0] rep_cand;
  logic             rep_found;
  logic [PW-1:0]    rep_idx;

  assign hd        = ent_q[head_q];
  assign hd_io     = hd.addr >= IO_BASE;
  assign disp_fire = disp_valid & ~flush & (count_q != CW'(DEPTH));
  assign full_next = count_q >= CW'(DEPTH - 1);
  assign pop       = busy_q & mem_done;
  assign issue_ok  = ~busy_q & vld_q[head_q] & hd.addr_ok &
                     (hd.is_st ? (hd.data_ok & hd.committed)
                               : (hd_io ? hd.committed : ~flush));

  // commit-gated entries that still owe a readiness report
  for (genvar g = 0; g < DEPTH; g++) begin : g_rep
    assign rep_cand[g] = vld_q[g] & ~flush & ~ent_q[g].reported & ent_q[g].addr_ok &
                         (ent_q[g].is_st ? ent_q[g].data_ok : (ent_q[g].addr >= IO_BASE));
  end

  mob_oldest_pick #(.DEPTH(DEPTH)) u_rep_pick (
    .cand(rep_cand), .start(head_q), .found(rep_found), .idx(rep_idx)
  );

  mob_popcount #(.N(DEPTH)) u_kept (.bits(vld_d), .ones(kept_cnt));

  // new entry, with same-cycle operand capture
  always_comb begin
    nent           = '0;
    nent.is_st     = disp_is_st;
    nent.rob_tag   = disp_rob_tag;
    nent.addr_q    = disp_addr_q;
    nent.data_q    = disp_data_q;
    nent.addr_ok   = disp_addr_ok | (wb_valid & (wb_tag == disp_addr_q));
    nent.addr      = disp_addr_ok ? disp_addr : wb_value;
    nent.data_ok   = ~disp_is_st | disp_data_ok | (wb_valid & (wb_tag == disp_data_q));
    nent.data      = disp_data_ok ? disp_data : wb_value;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_d[i] = ent_q[i];
      if (vld_q[i] && wb_valid) begin
        if (!ent_q[i].addr_ok && ent_q[i].addr_q == wb_tag) begin
          ent_d[i].addr_ok = 1'b1;
          ent_d[i].addr    = wb_value;
        end
        if (!ent_q[i].data_ok && ent_q[i].data_q == wb_tag) begin
          ent_d[i].data_ok = 1'b1;
          ent_d[i].data    = wb_value;
        end
      end
      if (vld_q[i] && commit_valid && ent_q[i].rob_tag == commit_tag)
        ent_d[i].committed = 1'b1;
    end
    if (rep_found) ent_d[rep_idx].reported = 1'b1;

    vld_d = vld_q;
    if (pop) vld_d[head_q] = 1'b0;
    if (flush) begin
      for (int i = 0; i < DEPTH; i++)
        if (!ent_d[i].committed && !(busy_q && !pop && PW'(i) == head_q))
          vld_d[i] = 1'b0;
    end
    if (disp_fire) begin
      ent_d[tail_q] = nent;
      vld_d[tail_q] = 1'b1;
    end

    head_d  = head_q + PW'(pop);
    count_d = flush ? kept_cnt : count_q + CW'(disp_fire) - CW'(pop);
    tail_d  = flush ? head_d + PW'(count_d) : tail_q + PW'(disp_fire);
    busy_d  = pop ? 1'b0 : (busy_q | issue_ok);
    kill_d  = pop ? 1'b0 : (kill_q | (flush & busy_q & ~hd.committed));
    ldv_d   = pop & ~hd.is_st & ~kill_q & ~(flush & ~hd.committed);
    rdyv_d  = rep_found;
    rdyt_d  = ent_q[rep_idx].rob_tag;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_q     <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      count_q   <= '0;
      busy_q    <= 1'b0;
      kill_q    <= 1'b0;
      rdy_valid <= 1'b0;
      ld_valid  <= 1'b0;
    end else begin
      vld_q     <= vld_d;
      head_q    <= head_d;
      tail_q    <= tail_d;
      count_q   <= count_d;
      busy_q    <= busy_d;
      kill_q    <= kill_d;
      rdy_valid <= rdyv_d;
      ld_valid  <= ldv_d;
    end
  end

  // payload registers: no reset, qualified by the valid bits
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    if (rdyv_d) rdy_tag <= rdyt_d;
    if (ldv_d) begin
      ld_tag  <= hd.rob_tag;
      ld_data <= mem_rdata;
    end
  end

  assign mem_req   = busy_q;
  assign mem_we    = hd.is_st;
  assign mem_addr  = hd.addr;
  assign mem_wdata = hd.data;
endmodule

// File: rtl/mob_chk.sv
module mob_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          mem_req,
  input logic          mem_we,
  input logic [31:0]   mem_addr,
  input logic          mem_done,
  input logic          ld_valid,
  input logic [CW-1:0] count_q,
  input logic          hd_committed
);
  // R3
  store_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && mem_we) |-> hd_committed);
  // R4
  ld_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_done && mem_req && !mem_we));
  // R4
  ld_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R9
  flush_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count_q <= $past(count_q));
endmodule

bind mem_order_buffer mob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_done(mem_done), .ld_valid(ld_valid),
  .count_q(count_q), .hd_committed(ent_q[head_q].committed)
);

// File: tb/mem_order_buffer_tb.sv
module mem_order_buffer_tb;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n;
  logic disp_valid, disp_is_st, disp_addr_ok, disp_data_ok;
  logic [3:0] disp_rob_tag, disp_addr_q, disp_data_q;
  logic [31:0] disp_addr, disp_data;
  logic full_next, wb_valid, rdy_valid, commit_valid, flush;
  logic [3:0] wb_tag, rdy_tag, commit_tag, ld_tag;
  logic [31:0] wb_value, mem_addr, mem_wdata, mem_rdata, ld_data;
  logic mem_req, mem_we, mem_done, ld_valid;

  always #4 clk = ~clk;

  mem_order_buffer #(.DEPTH(DEPTH)) u_dut (.*);

  int nchk = 0, nfail = 0, writes = 0, req_rises = 0, io_reads = 0, bcasts = 0;
  int lat = 2, cnt = 0;
  bit pend = 0, prev_req = 0, finished = 0;
  logic [31:0] mem [16], sh [16], last_wa, last_wd, io_next = 32'h40;
  logic [3:0] eq_tag [$], rq [$];
  logic [31:0] eq_val [$];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] sh_rd(input logic [31:0] a);
    return sh[a[5:2]];
  endfunction

  // memory model and output monitor, both on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_done = 1'b0; pend = 0; prev_req = 0;
    end else begin
      if (mem_req && !prev_req) req_rises++;
      prev_req = mem_req;
      if (rdy_valid) rq.push_back(rdy_tag);
      if (ld_valid) begin
        bcasts++;
        if (eq_tag.size() == 0) chk("R4 unexpected load tag", {28'd0, ld_tag}, 32'hFFFF);
        else begin
          chk("R4 load tag", {28'd0, ld_tag}, {28'd0, eq_tag.pop_front()});
          chk("R4 load data", ld_data, eq_val.pop_front());
        end
      end
      if (mem_done) mem_done = 1'b0;
      else if (pend) begin
        if (cnt == 0) begin
          mem_done = 1'b1; pend = 0;
          if (mem_we) begin
            mem[mem_addr[5:2]] = mem_wdata; writes++; last_wa = mem_addr; last_wd = mem_wdata;
          end else if (mem_addr >= 32'h30000) begin
            mem_rdata = io_next; io_next++; io_reads++;
          end else mem_rdata = mem[mem_addr[5:2]];
        end else cnt--;
      end else if (mem_req) begin
        pend = 1; cnt = lat;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic disp(input bit st, input bit aok, input logic [31:0] a, input logic [3:0] aq,
                      input bit dok, input logic [31:0] d, input logic [3:0] dq, input logic [3:0] t);
    disp_valid = 1; disp_is_st = st; disp_addr_ok = aok; disp_addr = a; disp_addr_q = aq;
    disp_data_ok = dok; disp_data = d; disp_data_q = dq; disp_rob_tag = t;
    tick(1);
    disp_valid = 0;
  endtask

  task automatic commit(input logic [3:0] t);
    commit_valid = 1; commit_tag = t; tick(1); commit_valid = 0;
  endtask

  task automatic expect_ld(input logic [3:0] t, input logic [31:0] v);
    eq_tag.push_back(t); eq_val.push_back(v);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    int w0, r0, b0, io0, seed, nst;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 16; i++) begin mem[i] = 32'h1000_0000 + i; sh[i] = mem[i]; end
    rst_n = 0; disp_valid = 0; disp_is_st = 0; disp_addr_ok = 0; disp_data_ok = 0;
    disp_rob_tag = 0; disp_addr_q = 0; disp_data_q = 0; disp_addr = 0; disp_data = 0;
    wb_valid = 0; wb_tag = 0; wb_value = 0; commit_valid = 0; commit_tag = 0; flush = 0;
    mem_rdata = 0; mem_done = 0;
    tick(3); rst_n = 1; tick(4);

    // R1 reset state
    chk("R1 full_next", {31'd0, full_next}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    chk("R1 ld_valid", {31'd0, ld_valid}, 0);
    chk("R1 rdy_valid", {31'd0, rdy_valid}, 0);

    // R2 / R3 store held until commit
    r0 = req_rises; w0 = writes;
    disp(1, 1, 32'h8, 0, 1, 32'hA5A5_0001, 0, 4'd1); sh[2] = 32'hA5A5_0001;
    tick(6);
    chk("R2 store report count", rq.size(), 1);
    if (rq.size() > 0) chk("R2 store report tag", {28'd0, rq.pop_front()}, 1);
    chk("R3 no request before commit", req_rises - r0, 0);
    commit(4'd1); tick(8);
    chk("R3 one write after commit", writes - w0, 1);
    chk("R3 write addr", last_wa, 32'h8);
    chk("R3 write data", last_wd, 32'hA5A5_0001);

    // R4 ordinary load
    b0 = bcasts;
    expect_ld(4'd2, sh_rd(32'h8));
    disp(0, 1, 32'h8, 0, 0, 0, 0, 4'd2); tick(8);
    chk("R4 one broadcast", bcasts - b0, 1);

    // R5 IO load held until commit
    r0 = req_rises; io0 = io_reads;
    disp(0, 1, 32'h30000, 0, 0, 0, 0, 4'd3); tick(6);
    chk("R5 io load reported", rq.size(), 1);
    if (rq.size() > 0) chk("R5 io report tag", {28'd0, rq.pop_front()}, 3);
    chk("R5 no io request before commit", req_rises - r0, 0);
    expect_ld(4'd3, io_next);
    commit(4'd3); tick(8);
    chk("R5 io read after commit", io_reads - io0, 1);

    // R7 wakeup, later and same-cycle
    r0 = req_rises;
    disp(0, 0, 0, 4'd9, 0, 0, 0, 4'd4); tick(4);
    chk("R7 waits for address", req_rises - r0, 0);
    expect_ld(4'd4, sh_rd(32'h8));
    wb_valid = 1; wb_tag = 9; wb_value = 32'h8; tick(1); wb_valid = 0; tick(8);
    expect_ld(4'd5, sh_rd(32'h4));
    wb_valid = 1; wb_tag = 10; wb_value = 32'h4;
    disp(0, 0, 0, 4'd10, 0, 0, 0, 4'd5); wb_valid = 0; tick(8);
    chk("R7 both loads done", eq_tag.size(), 0);
    w0 = writes;
    disp(1, 1, 32'hC, 0, 0, 0, 4'd11, 4'd6); tick(4);
    chk("R7 store waits for data", rq.size(), 0);
    wb_valid = 1; wb_tag = 11; wb_value = 32'h77; tick(1); wb_valid = 0; tick(4);
    chk("R2 store reported after data", rq.size(), 1);
    rq.delete(); sh[3] = 32'h77;
    commit(4'd6); tick(8);
    chk("R7 store data from bus", last_wd, 32'h77);

    // R8 early full and drop when full
    w0 = writes;
    for (int i = 0; i < DEPTH - 2; i++) disp(1, 1, 32'h10 + i*4, 0, 1, 32'hB000 + i, 0, 4'(i));
    chk("R8 full_next low at DEPTH-2", {31'd0, full_next}, 0);
    disp(1, 1, 32'h10 + (DEPTH-2)*4, 0, 1, 32'hB000 + DEPTH - 2, 0, 4'(DEPTH - 2));
    chk("R8 full_next high at DEPTH-1", {31'd0, full_next}, 1);
    disp(1, 1, 32'h10 + (DEPTH-1)*4, 0, 1, 32'hB000 + DEPTH - 1, 0, 4'(DEPTH - 1));
    disp(1, 1, 32'h3C, 0, 1, 32'hDEAD, 0, 4'd12);
    for (int i = 0; i < DEPTH; i++) sh[4 + i] = 32'hB000 + i;
    tick(4);
    for (int i = 0; i < DEPTH; i++) commit(4'(i));
    commit(4'd12);
    tick(40); rq.delete();
    chk("R8 exactly DEPTH writes", writes - w0, DEPTH);
    chk("R8 last write is last accepted", last_wd, 32'hB000 + DEPTH - 1);
    chk("R8 full_next low when empty", {31'd0, full_next}, 0);

    // R9 flush keeps committed store only
    w0 = writes; b0 = bcasts;
    disp(1, 1, 32'h20, 0, 1, 32'h1111, 0, 4'd1); sh[8] = 32'h1111;
    disp(1, 1, 32'h24, 0, 1, 32'h2222, 0, 4'd2);
    disp(0, 1, 32'h20, 0, 0, 0, 0, 4'd3);
    tick(4);
    commit_valid = 1; commit_tag = 1; flush = 1; tick(1); commit_valid = 0;
    disp(0, 1, 32'h24, 0, 0, 0, 0, 4'd4);
    tick(1); flush = 0; tick(12); rq.delete();
    chk("R9 only committed store written", writes - w0, 1);
    chk("R9 committed store data", last_wd, 32'h1111);
    chk("R9 no speculative broadcast", bcasts - b0, 0);
    expect_ld(4'd5, sh_rd(32'h24));
    disp(0, 1, 32'h24, 0, 0, 0, 0, 4'd5); tick(8);
    chk("R9 dropped store left memory unchanged", eq_tag.size(), 0);

    // R10 in-flight uncommitted load, and dropped IO load
    b0 = bcasts; r0 = req_rises; io0 = io_reads;
    disp(0, 1, 32'h20, 0, 0, 0, 0, 4'd6);
    tick(1); flush = 1; tick(2); flush = 0; tick(8);
    chk("R10 load was issued", req_rises - r0, 1);
    chk("R10 no broadcast after flush", bcasts - b0, 0);
    disp(0, 1, 32'h30004, 0, 0, 0, 0, 4'd7); tick(3);
    flush = 1; tick(2); flush = 0; tick(8); rq.delete();
    chk("R9 flushed io load read nothing", io_reads - io0, 0);

    // constrained random traffic
    w0 = writes; nst = 0;
    begin
      logic [3:0] tg;
      tg = 0;
      for (int c = 0; c < 2000; c++) begin
        lat = int'($urandom_range(0, 2));
        disp_valid = 0; commit_valid = 0;
        if (rq.size() > 0) begin commit_valid = 1; commit_tag = rq.pop_front(); end
        if (!full_next && $urandom_range(0, 99) < 60) begin
          logic [31:0] a;
          a = {26'd0, 4'($urandom_range(0, 15)), 2'b00};
          disp_valid = 1; disp_addr_ok = 1; disp_addr = a; disp_data_ok = 1;
          disp_rob_tag = tg; disp_is_st = $urandom_range(0, 1) == 1;
          disp_data = $urandom;
          if (disp_is_st) begin sh[a[5:2]] = disp_data; nst++; end
          else expect_ld(tg, sh_rd(a));
          tg++;
        end
        if ($urandom_range(0, 9) == 0) begin wb_valid = 1; wb_tag = 4'($urandom); wb_value = $urandom; end
        else wb_valid = 0;
        tick(1);
      end
      disp_valid = 0; wb_valid = 0;
      for (int c = 0; c < 400; c++) begin
        commit_valid = 0;
        if (rq.size() > 0) begin commit_valid = 1; commit_tag = rq.pop_front(); end
        tick(1);
      end
      commit_valid = 0;
    end
    chk("R4 random loads all returned", eq_tag.size(), 0);
    chk("R3 random stores all written", writes - w0, nst);
    for (int i = 0; i < 16; i++) chk("R6 memory image in order", mem[i], sh[i]);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule